// File: doc/BRIEF.md
# Segment-Swapping Wear Leveler

This block sits in front of an endurance-limited memory split into equal segments. Each incoming word address carries a logical segment number and a word offset. A remap table turns the segment number into a physical segment, and the block serves the read or write from a behavioural word array at that physical location. Every physical segment has a write counter, because wear builds up in the cells and not in the logical addresses.

Once a programmed number of writes has been accepted, the block stops taking requests. It scans the counters one per cycle to find the most-worn and least-worn physical segments. If the two differ and their counts are far enough apart, the block exchanges their contents word by word through a holding register. It then rewrites both table entries in one cycle. Frequently written logical data moves onto fresh cells, and every later access follows the new table, so software never sees the move.

Top module: `seg_wear_leveler`

## Requirements
- R1: `phys_addr` equals the request address with its upper log2(NSEG) bits (the segment field) replaced by the table entry for that logical segment. The low log2(SEG_WORDS) offset bits pass through unchanged. After reset the table is the identity.
- R2: An accepted read returns, on `rd_data` with `rd_valid` high one cycle later, the last value written to the same logical address. This holds across any number of swaps.
- R3: Each accepted write adds one to the counter of the physical segment it lands in.
- R4: A maintenance pass starts on the accepted write that brings the number of writes since the previous pass to `swap_period` or more. When `swap_period` is zero, no pass ever starts.
- R5: The scan picks as hot the physical segment with the highest count, and as cold the one with the lowest count. On a tie, the lowest index wins in both cases.
- R6: If hot equals cold, or their counts differ by less than MIN_GAP, nothing moves. `req_ready` is then low for exactly NSEG+1 cycles.
- R7: Otherwise the contents of the hot and cold physical segments are exchanged, along with the two table entries that point at them. `req_ready` is then low for exactly NSEG+2+2*SEG_WORDS cycles.
- R8: While `req_ready` is low, a request is ignored: it changes no memory word and no counter.
- R9: Out of reset, `req_ready` is high and no pass is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| swap_period | input | CW | Accepted writes between maintenance passes; 0 disables them |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | AW | Logical word address: segment field above offset field |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request is accepted this cycle when high |
| phys_addr | output | AW | Translated word address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DW | Read data |

## Verification
Writes are concentrated on one logical segment and then a pass is forced. This separates a real exchange from a skipped one: it shows in the stall length, in the translated address of the hot and cold logical segments, and in data read back after the move. A run with every segment written equally makes the hot and cold picks coincide on segment 0. A small skew that stays under the gap tells the gap test apart from the equality test. A write presented during the stall, and a long run with the period at zero, check that ignored requests and a disabled period leave data and timing untouched.

// File: rtl/seg_wear_leveler.sv
module seg_wear_leveler #(
  parameter int NSEG      = 16,
  parameter int SEG_WORDS = 64,
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int MIN_GAP   = 8,
  localparam int SW = $clog2(NSEG),
  localparam int OW = $clog2(SEG_WORDS),
  localparam int AW = SW + OW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] swap_period,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic [AW-1:0] phys_addr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  typedef enum logic [2:0] {IDLE, SCAN, DECIDE, CP_RD, CP_WR, COMMIT} st_t;

  st_t           state;
  logic [SW-1:0] l2p [NSEG];
  logic [SW-1:0] p2l [NSEG];
  logic [CW-1:0] wcnt [NSEG];
  logic [CW-1:0] since;
  logic [SW-1:0] idx, hot, cold;
  logic [CW-1:0] hi, lo;
  logic [OW-1:0] k;
  logic [DW-1:0] tmp;
  logic [DW-1:0] mem [NSEG*SEG_WORDS];

  logic          acc, acc_wr;
  logic [SW-1:0] pseg;
  logic [CW-1:0] since_nx;
  logic          trig;

  assign req_ready = (state == IDLE);
  assign acc       = req_ready && req_valid;
  assign acc_wr    = acc && req_write;
  assign pseg      = l2p[req_addr[AW-1:OW]];
  assign phys_addr = {pseg, req_addr[OW-1:0]};
  assign since_nx  = (since == {CW{1'b1}}) ? since : since + 1'b1;
  assign trig      = acc_wr && (swap_period != '0) && (since_nx >= swap_period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= IDLE;
      since    <= '0;
      idx      <= '0;
      hot      <= '0;
      cold     <= '0;
      hi       <= '0;
      lo       <= '1;
      k        <= '0;
      rd_valid <= 1'b0;
      for (int i = 0; i < NSEG; i++) begin
        l2p[i]  <= SW'(i);
        p2l[i]  <= SW'(i);
        wcnt[i] <= '0;
      end
    end else begin
      rd_valid <= acc && !req_write;
      case (state)
        IDLE: begin
          if (acc_wr) begin
            if (wcnt[pseg] != {CW{1'b1}}) wcnt[pseg] <= wcnt[pseg] + 1'b1;
            since <= trig ? '0 : since_nx;
          end
          if (trig) begin
            state <= SCAN;
            idx   <= '0;
            hot   <= '0;
            cold  <= '0;
            hi    <= '0;
            lo    <= '1;
          end
        end
        SCAN: begin
          if (wcnt[idx] > hi) begin
            hi  <= wcnt[idx];
            hot <= idx;
          end
          if (wcnt[idx] < lo) begin
            lo   <= wcnt[idx];
            cold <= idx;
          end
          idx <= idx + 1'b1;
          if (idx == SW'(NSEG-1)) state <= DECIDE;
        end
        DECIDE: begin
          k <= '0;
          if (hot == cold || (hi - lo) < CW'(MIN_GAP)) state <= IDLE;
          else state <= CP_RD;
        end
        CP_RD: state <= CP_WR;
        CP_WR: begin
          k <= k + 1'b1;
          if (k == OW'(SEG_WORDS-1)) state <= COMMIT;
          else state <= CP_RD;
        end
        COMMIT: begin
          l2p[p2l[hot]]  <= cold;
          l2p[p2l[cold]] <= hot;
          p2l[hot]       <= p2l[cold];
          p2l[cold]      <= p2l[hot];
          state          <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (acc_wr) mem[phys_addr] <= req_wdata;
    if (acc && !req_write) rd_data <= mem[phys_addr];
    if (state == CP_RD) tmp <= mem[{cold, k}];
    if (state == CP_WR) begin
      mem[{cold, k}] <= mem[{hot, k}];
      mem[{hot, k}]  <= tmp;
    end
  end

  generate
    for (genvar g = 0; g < NSEG; g++) begin : g_chk
      a_r7_table_bijective: assert property (@(posedge clk) disable iff (!rst_n)
        p2l[l2p[g]] == SW'(g));
      a_r3_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt[g] >= $past(wcnt[g]));
      a_r8_stall_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$rose(!req_ready)) |-> $stable(wcnt[g]));
    end
  endgenerate

  a_r6_gap_before_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CP_RD && k == '0) |-> (hot != cold && (hi - lo) >= CW'(MIN_GAP)));
  a_r2_read_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && req_ready && !req_write));
  a_r4_since_cleared_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> since == '0);

endmodule

// File: tb/seg_wear_leveler_tb_top.sv
module seg_wear_leveler_tb_top;
  localparam int NSEG = 16, SEG_WORDS = 64, DW = 16, CW = 16, MIN_GAP = 8;
  localparam int SW = $clog2(NSEG), OW = $clog2(SEG_WORDS), AW = SW + OW;
  localparam int NOSWAP_LEN = NSEG + 1;
  localparam int SWAP_LEN   = NSEG + 2 + 2 * SEG_WORDS;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] swap_period = '0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid;
  logic [AW-1:0] phys_addr;
  logic [DW-1:0] rd_data;

  int total = 0, bad = 0;
  int map_m [NSEG];
  int cnt_m [NSEG];
  int mem_m [NSEG*SEG_WORDS];
  int since_m;

  seg_wear_leveler #(.NSEG(NSEG), .SEG_WORDS(SEG_WORDS), .DW(DW), .CW(CW), .MIN_GAP(MIN_GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .swap_period(swap_period), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .phys_addr(phys_addr), .rd_valid(rd_valid), .rd_data(rd_data));

  always #4 clk = ~clk;

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    req_valid = 0; swap_period = '0;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NSEG; i++) begin map_m[i] = i; cnt_m[i] = 0; end
    since_m = 0;
  endtask

  task automatic stall_check(input bit inject, input int inj_addr);
    int hot, cold, hi, lo, n, exp_len, la, lb;
    bit sw;
    hot = 0; cold = 0; hi = 0; lo = (1 << CW) - 1;
    for (int i = 0; i < NSEG; i++) begin
      if (cnt_m[i] > hi) begin hi = cnt_m[i]; hot = i; end
      if (cnt_m[i] < lo) begin lo = cnt_m[i]; cold = i; end
    end
    sw = (hot != cold) && (hi - lo >= MIN_GAP);
    exp_len = sw ? SWAP_LEN : NOSWAP_LEN;
    n = 0;
    while (!req_ready && n < 1000) begin
      if (inject && n == 0) begin
        req_valid = 1; req_write = 1; req_addr = AW'(inj_addr); req_wdata = 16'hDEAD;
      end else req_valid = 0;
      n++;
      @(negedge clk);
    end
    req_valid = 0;
    chk(n == exp_len, sw ? "R7 swap stall length" : "R6 skip stall length", n, exp_len);
    if (sw) begin
      la = 0; lb = 0;
      for (int i = 0; i < NSEG; i++) begin
        if (map_m[i] == hot) la = i;
        if (map_m[i] == cold) lb = i;
      end
      map_m[la] = cold; map_m[lb] = hot;
    end
  endtask

  task automatic do_write(input int la, input int data, input bit inject, input int inj_addr);
    int ps;
    bit trig;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = AW'(la); req_wdata = DW'(data);
    @(posedge clk);
    ps = map_m[la >> OW];
    cnt_m[ps]++;
    mem_m[la] = data;
    since_m++;
    trig = (swap_period != 0) && (since_m >= int'(swap_period));
    if (trig) since_m = 0;
    @(negedge clk);
    req_valid = 0;
    if (trig) stall_check(inject, inj_addr);
    else chk(req_ready == 1'b1, "R4 no pass started", int'(req_ready), 1);
  endtask

  task automatic do_read(input int la, input string req);
    int exp_pa;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = AW'(la);
    #1;
    exp_pa = (map_m[la >> OW] << OW) | (la & (SEG_WORDS - 1));
    chk(int'(phys_addr) == exp_pa, "R1 translated address", int'(phys_addr), exp_pa);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(rd_valid == 1'b1, "R2 read valid", int'(rd_valid), 1);
    chk(int'(rd_data) == mem_m[la], req, int'(rd_data), mem_m[la]);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(req_ready == 1'b1, "R9 ready after reset", int'(req_ready), 1);
    for (int s = 0; s < NSEG; s += 5) begin
      req_addr = AW'((s << OW) | 3);
      #1;
      chk(int'(phys_addr) == ((s << OW) | 3), "R1 identity map after reset", int'(phys_addr), (s << OW) | 3);
    end
  endtask

  task automatic t_period_zero();
    do_reset();
    for (int i = 0; i < 40; i++) do_write((7 << OW) | (i % SEG_WORDS), 100 + i, 0, 0);
    do_read((7 << OW) | 5, "R2 readback with period zero (R4)");
  endtask

  task automatic t_hot_swap();
    do_reset();
    for (int i = 0; i < 20; i++) do_write((5 << OW) | i, 16'h5000 + i, 0, 0);
    do_write((9 << OW), 16'h9999, 0, 0);
    swap_period = 1;
    do_write((2 << OW) | 7, 16'h2227, 1, (9 << OW));
    swap_period = 0;
    chk(map_m[5] == 0 && map_m[0] == 5, "R5 hot seg 5 cold seg 0 picked", map_m[5], 0);
    for (int i = 0; i < 20; i += 6) do_read((5 << OW) | i, "R7 moved data readback");
    do_read((9 << OW), "R8 stalled write ignored");
    do_read((2 << OW) | 7, "R2 trigger write readback");
    do_write((5 << OW) | 1, 16'h7777, 0, 0);
    do_read((5 << OW) | 1, "R2 write after swap");
    do_read((0 << OW) | 1, "R3 cold slot not touched via seg 0");
  endtask

  task automatic t_all_equal();
    do_reset();
    swap_period = NSEG;
    for (int s = 0; s < NSEG; s++) do_write((s << OW) | 2, 16'h0100 + s, 0, 0);
    swap_period = 0;
    for (int s = 0; s < NSEG; s += 3) do_read((s << OW) | 2, "R6 equal counts nothing moved");
  endtask

  task automatic t_small_gap();
    do_reset();
    for (int i = 0; i < 5; i++) do_write((11 << OW) | i, 16'h0B00 + i, 0, 0);
    swap_period = 1;
    do_write((11 << OW) | 9, 16'h0B09, 0, 0);
    swap_period = 0;
    do_read((11 << OW) | 9, "R6 gap below threshold kept map");
    do_read((11 << OW) | 0, "R3 count path data intact");
  endtask

  initial begin
    t_reset_state();
    t_period_zero();
    t_hot_swap();
    t_all_equal();
    t_small_gap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule